// File: doc/BRIEF.md
# Masked Alarm and Interrupt Controller

This block watches the running time of a real-time clock and raises an alarm when the time matches a programmed alarm setting. The seconds, minutes, hours and day-of-month fields are compared against four alarm registers. Each alarm register carries a mask bit that takes its field out of the comparison. The combination of mask bits picks how often the alarm repeats: every second, every minute, every hour, every day, or once a month on a given date. A match sets a sticky alarm flag.

The flag reaches a shared active-low interrupt pin only when enable bits allow it. There is one rule for main power and a stricter one for battery operation. Software clears the flag and releases the pin by reading or writing the flag register. The clear takes effect only when that bus access ends. The same pin can instead carry a 512 Hz square wave for measuring the oscillator, toggling on every strobe of a 1024 Hz half-period input. A power-up event clears the enable and test bits but keeps the flag, so software can learn that an alarm fired while system power was off.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After the synchronous active-low reset, the flag (bit 0 of register 0), the control register (register 1) and all four alarm registers (registers 2 to 5) read zero, and `irq_n` is high.
- R2: Each alarm register holds a mask in bit 7 and a compare value in bits 6:0. Register 2 is seconds, 3 minutes, 4 hours, 5 date. The masks written as {date,hour,min,sec} select the mode: 0000 matches date, hour, minute and second; 1000 matches hour, minute and second; 1100 matches minute and second; 1110 matches second only; 1111 matches every second.
- R3: Any mask combination not listed in R2 behaves as a match on every second.
- R4: Matching is evaluated only in the cycle where `sec_tick` is high. A match sets the flag on that clock edge. A time that matches without a tick sets nothing.
- R5: On main power (`on_batt` low), `irq_n` is low exactly when the flag is set and alarm-enable (control bit 0) is 1. The flag is set whether or not the enable is 1.
- R6: A read or write of register 0 leaves the flag and `irq_n` unchanged while `bus_cs` stays high. Both are cleared on the first clock edge with `bus_cs` low. Write data to register 0 is ignored.
- R7: On battery (`on_batt` high), `irq_n` goes low for a set flag only when alarm-enable and battery-alarm-enable (control bit 1) are both 1.
- R8: A `pwr_up` pulse clears alarm-enable, battery-alarm-enable and frequency-test (control bit 2), and keeps the flag and the alarm registers.
- R9: With frequency-test at 1, alarm-enable at 0, and `wd_to_rst` or `wd_zero` high, `irq_n` starts high and inverts on each clock edge where `half_tick` is high. Otherwise `irq_n` follows R5 and R7, and `half_tick` has no effect.
- R10: When a match and the end-of-access clear of R6 fall on the same clock edge, the flag stays set.
- R11: The control register and the alarm registers read back the values last written, the control register in bits 2:0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe when the time fields advance |
| tm_sec | input | 7 | Current seconds, BCD |
| tm_min | input | 7 | Current minutes, BCD |
| tm_hour | input | 7 | Current hours, BCD |
| tm_date | input | 7 | Current day of month, BCD |
| on_batt | input | 1 | High while running from the backup battery |
| pwr_up | input | 1 | One-cycle strobe on return of main power |
| wd_to_rst | input | 1 | Watchdog is steered to the reset output |
| wd_zero | input | 1 | Watchdog timeout register holds zero |
| half_tick | input | 1 | 1024 Hz strobe, one half period of the test wave |
| bus_cs | input | 1 | Register access active, held for the whole access |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq_n | output | 1 | Active-low interrupt or test square wave |

## Verification
The match logic is driven with time vectors that differ from the alarm in one field at a time. Under each legal mask mode this shows that exactly the masked fields are ignored and the unmasked ones still block a match. Undefined masks that hide a low field and ones that hide a high field both show the once-per-second fallback. Flag accesses held over several cycles separate a clear at the end of the access from a clear at its start. A match placed on the clearing edge shows which of the two wins. Toggling the battery indicator, the power-up strobe and the watchdog conditions under fixed enables shows each gate on the pin separately.

// File: rtl/alarm_pkg.sv
// Shared constants and types of the alarm and interrupt controller.
// Assumes a 3-bit register select and four compared time fields.
package alarm_pkg;
    localparam int unsigned ADDR_W     = 3;
    localparam int unsigned NUM_FIELDS = 4;

    typedef logic [ADDR_W-1:0] addr_t;

    // Register map; the alarm registers are consecutive from A_SEC.
    localparam addr_t A_FLAG = 3'd0;
    localparam addr_t A_CTRL = 3'd1;
    localparam addr_t A_SEC  = 3'd2;
    localparam addr_t A_MIN  = 3'd3;
    localparam addr_t A_HOUR = 3'd4;
    localparam addr_t A_DATE = 3'd5;

    // Bits of the control register.
    localparam int unsigned C_AE  = 0;
    localparam int unsigned C_ABE = 1;
    localparam int unsigned C_FT  = 2;

    // Repetition modes selected by the mask bits.
    typedef enum logic [2:0] {
        RPT_SECOND,
        RPT_MINUTE,
        RPT_HOUR,
        RPT_DAY,
        RPT_DATE
    } rpt_e;
endpackage

// File: rtl/alarm_match.sv
// Alarm comparator: decodes the four mask bits into a repetition mode and
// compares the unmasked fields on a seconds tick.
// Assumes the mask is the MSB of each alarm field and the value the rest.
module alarm_match
    import alarm_pkg::*;
#(
    parameter int unsigned FIELD_W = 8
) (
    input  logic                                    sec_tick_i,
    input  logic [NUM_FIELDS-1:0][FIELD_W-2:0]     now_i,
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]     alarm_i,
    output logic                                    match_o
);
    localparam int unsigned VAL_W = FIELD_W - 1;

    logic [NUM_FIELDS-1:0] eq;
    logic [NUM_FIELDS-1:0] mask;
    logic [NUM_FIELDS-1:0] need;
    rpt_e                  mode;

    // Per-field equality and mask extraction.
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        assign eq[i]   = (now_i[i] == alarm_i[i][VAL_W-1:0]);
        assign mask[i] = alarm_i[i][FIELD_W-1];
    end

    // Mask pattern to mode; undefined patterns fall back to every second.
    always_comb begin
        case (mask)
            4'b0000: mode = RPT_DATE;
            4'b1000: mode = RPT_DAY;
            4'b1100: mode = RPT_HOUR;
            4'b1110: mode = RPT_MINUTE;
            default: mode = RPT_SECOND;
        endcase
    end

    // Mode to set of fields that must be equal.
    always_comb begin
        case (mode)
            RPT_DATE:   need = 4'b1111;
            RPT_DAY:    need = 4'b0111;
            RPT_HOUR:   need = 4'b0011;
            RPT_MINUTE: need = 4'b0001;
            default:    need = 4'b0000;
        endcase
    end

    assign match_o = sec_tick_i & (&(eq | ~need));
endmodule

// File: rtl/alarm_regs.sv
// Register file of the controller: alarm fields, enables and the alarm flag.
// The flag is set by a match and cleared on the first edge after an access
// to the flag register ends. A power-up strobe drops the enables only.
module alarm_regs
    import alarm_pkg::*;
#(
    parameter int unsigned FIELD_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_cs_i,
    input  logic                                bus_we_i,
    input  addr_t                               bus_addr_i,
    input  logic [FIELD_W-1:0]                  bus_wdata_i,
    output logic [FIELD_W-1:0]                  bus_rdata_o,
    input  logic                                match_i,
    input  logic                                pwr_up_i,
    output logic [NUM_FIELDS-1:0][FIELD_W-1:0]  alarm_o,
    output logic                                af_o,
    output logic                                ae_o,
    output logic                                abe_o,
    output logic                                ft_o
);
    logic [FIELD_W-1:0] al_q [NUM_FIELDS];
    logic               af_q, ae_q, abe_q, ft_q, pend_q;
    logic               wr_en, flag_sel;

    assign wr_en    = bus_cs_i & bus_we_i;
    assign flag_sel = bus_cs_i & (bus_addr_i == A_FLAG);

    // One register per alarm field, written by address.
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_alarm
        always_ff @(posedge clk) begin // load alarm field i
            if (!rst_n)
                al_q[i] <= '0;
            else if (wr_en && bus_addr_i == addr_t'(int'(A_SEC) + i))
                al_q[i] <= bus_wdata_i;
        end
        assign alarm_o[i] = al_q[i];
    end

    // Control bits; a power-up strobe overrides a write.
    always_ff @(posedge clk) begin // enables and test bit
        if (!rst_n || pwr_up_i) begin
            ae_q  <= 1'b0;
            abe_q <= 1'b0;
            ft_q  <= 1'b0;
        end else if (wr_en && bus_addr_i == A_CTRL) begin
            ae_q  <= bus_wdata_i[C_AE];
            abe_q <= bus_wdata_i[C_ABE];
            ft_q  <= bus_wdata_i[C_FT];
        end
    end

    // Remember an access to the flag register until the access ends.
    always_ff @(posedge clk) begin // pending clear
        if (!rst_n)
            pend_q <= 1'b0;
        else if (flag_sel)
            pend_q <= 1'b1;
        else if (!bus_cs_i)
            pend_q <= 1'b0;
    end

    // Alarm flag: set by a match, which wins over a deferred clear.
    always_ff @(posedge clk) begin // sticky flag
        if (!rst_n)
            af_q <= 1'b0;
        else if (match_i)
            af_q <= 1'b1;
        else if (pend_q && !bus_cs_i)
            af_q <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_FLAG: bus_rdata_o[0] = af_q;
            A_CTRL: begin
                bus_rdata_o[C_AE]  = ae_q;
                bus_rdata_o[C_ABE] = abe_q;
                bus_rdata_o[C_FT]  = ft_q;
            end
            default: begin
                for (int k = 0; k < NUM_FIELDS; k++)
                    if (bus_addr_i == addr_t'(int'(A_SEC) + k))
                        bus_rdata_o = al_q[k];
            end
        endcase
    end

    assign af_o  = af_q;
    assign ae_o  = ae_q;
    assign abe_o = abe_q;
    assign ft_o  = ft_q;

    a_r4_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> af_o);
    a_r6_hold_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_i && $past(af_o)) |-> af_o);
    a_r6_release_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !bus_cs_i && !match_i) |=> !af_o);
    a_r8_flag_survives_powerup: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_up_i && af_o && !(pend_q && !bus_cs_i)) |=> af_o);
    a_r8_enables_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_up_i |=> (!ae_o && !abe_o && !ft_o));
endmodule

// File: rtl/pin_drive.sv
// Drives the shared active-low pin: either the gated alarm interrupt or a
// square wave toggled by half-period strobes for oscillator measurement.
// Assumes half_tick is a one-cycle strobe at twice the wave frequency.
module pin_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic af_i,
    input  logic ae_i,
    input  logic abe_i,
    input  logic ft_i,
    input  logic on_batt_i,
    input  logic wd_to_rst_i,
    input  logic wd_zero_i,
    input  logic half_tick_i,
    output logic irq_n_o
);
    logic sq_en, sq_lvl_q, irq_act;

    assign sq_en   = ft_i & ~ae_i & (wd_to_rst_i | wd_zero_i);
    assign irq_act = af_i & ae_i & (~on_batt_i | abe_i);

    // Square wave level, parked high while the test mode is off.
    always_ff @(posedge clk) begin // test wave
        if (!rst_n || !sq_en)
            sq_lvl_q <= 1'b1;
        else if (half_tick_i)
            sq_lvl_q <= ~sq_lvl_q;
    end

    assign irq_n_o = sq_en ? sq_lvl_q : ~irq_act;

    a_r7_battery_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (on_batt_i && !abe_i && !sq_en) |-> irq_n_o);
    a_r9_square_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_en && $past(sq_en) && $past(half_tick_i)) |-> (irq_n_o != $past(irq_n_o)));
endmodule

// File: rtl/alarm_irq_ctrl.sv
// Top of the masked alarm and interrupt controller: matcher, register file
// and pin driver. Assumes the time fields change only with sec_tick.
module alarm_irq_ctrl
    import alarm_pkg::*;
#(
    parameter int unsigned FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_tick,
    input  logic [FIELD_W-2:0] tm_sec,
    input  logic [FIELD_W-2:0] tm_min,
    input  logic [FIELD_W-2:0] tm_hour,
    input  logic [FIELD_W-2:0] tm_date,
    input  logic               on_batt,
    input  logic               pwr_up,
    input  logic               wd_to_rst,
    input  logic               wd_zero,
    input  logic               half_tick,
    input  logic               bus_cs,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [FIELD_W-1:0] bus_wdata,
    output logic [FIELD_W-1:0] bus_rdata,
    output logic               irq_n
);
    logic [NUM_FIELDS-1:0][FIELD_W-2:0] now;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm;
    logic match, af, ae, abe, ft;

    assign now = {tm_date, tm_hour, tm_min, tm_sec};

    alarm_match #(.FIELD_W(FIELD_W)) i_match (
        .sec_tick_i (sec_tick),
        .now_i      (now),
        .alarm_i    (alarm),
        .match_o    (match)
    );

    alarm_regs #(.FIELD_W(FIELD_W)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_cs_i    (bus_cs),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .match_i     (match),
        .pwr_up_i    (pwr_up),
        .alarm_o     (alarm),
        .af_o        (af),
        .ae_o        (ae),
        .abe_o       (abe),
        .ft_o        (ft)
    );

    pin_drive i_pin (
        .clk         (clk),
        .rst_n       (rst_n),
        .af_i        (af),
        .ae_i        (ae),
        .abe_i       (abe),
        .ft_i        (ft),
        .on_batt_i   (on_batt),
        .wd_to_rst_i (wd_to_rst),
        .wd_zero_i   (wd_zero),
        .half_tick_i (half_tick),
        .irq_n_o     (irq_n)
    );
endmodule

// File: tb/test_alarm_irq_ctrl.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares
// them mid-way through the high phase of the clock.
module test_alarm_irq_ctrl;
    import alarm_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0, sec_tick = 1'b0, on_batt = 1'b0, pwr_up = 1'b0;
    logic       wd_to_rst = 1'b0, wd_zero = 1'b0, half_tick = 1'b0;
    logic       bus_cs = 1'b0, bus_we = 1'b0;
    logic [6:0] tm_sec = '0, tm_min = '0, tm_hour = '0, tm_date = '0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_n;

    alarm_irq_ctrl i_alarm_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_date(tm_date),
        .on_batt(on_batt), .pwr_up(pwr_up), .wd_to_rst(wd_to_rst),
        .wd_zero(wd_zero), .half_tick(half_tick), .bus_cs(bus_cs),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    typedef struct {
        bit         is_pin;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Monitor: compare every queued item against the outputs.
    initial forever begin
        @(posedge clk);
        #2;
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if (it.is_pin) begin
                if (irq_n !== it.exp[0]) begin
                    n_fail++;
                    $display("FAIL %s: irq_n actual %b expected %b", it.tag, irq_n, it.exp[0]);
                end
            end else if (bus_rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s: rdata actual %h expected %h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic push_pin(logic v, string tag);
        item_t it;
        it.is_pin = 1'b1; it.exp = {7'b0, v}; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic push_rd(logic [7:0] v, string tag);
        item_t it;
        it.is_pin = 1'b0; it.exp = v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic expect_pin(logic v, string tag);
        push_pin(v, tag);
        @(negedge clk);
    endtask

    task automatic wr(addr_t a, logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_chk(addr_t a, logic [7:0] v, string tag);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        push_rd(v, tag);
        @(negedge clk);
        bus_cs = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic half();
        @(negedge clk); half_tick = 1'b1;
        @(negedge clk); half_tick = 1'b0;
    endtask

    task automatic set_alarm(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d);
        wr(A_SEC, s); wr(A_MIN, m); wr(A_HOUR, h); wr(A_DATE, d);
    endtask

    // Present a time, tick once, check the pin, then clear the flag.
    task automatic fire(logic [6:0] s, logic [6:0] m, logic [6:0] h, logic [6:0] d,
                        bit hit, string tag);
        tm_sec = s; tm_min = m; tm_hour = h; tm_date = d;
        tick();
        expect_pin(!hit, tag);
        wr(A_FLAG, 8'h00);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_pin(1'b1, "R1 pin idle");
        rd_chk(A_FLAG, 8'h00, "R1 flag");
        rd_chk(A_CTRL, 8'h00, "R1 ctrl");
        rd_chk(A_SEC, 8'h00, "R1 alarm sec");

        // R11 readback
        set_alarm(8'h30, 8'h15, 8'h08, 8'h12);
        rd_chk(A_SEC, 8'h30, "R11 sec");
        rd_chk(A_MIN, 8'h15, "R11 min");
        rd_chk(A_HOUR, 8'h08, "R11 hour");
        rd_chk(A_DATE, 8'h12, "R11 date");
        wr(A_CTRL, 8'hF9);
        rd_chk(A_CTRL, 8'h01, "R11 ctrl");

        // R2 date mode
        fire(7'h30, 7'h15, 7'h08, 7'h13, 1'b0, "R2 date differs");
        fire(7'h30, 7'h15, 7'h08, 7'h12, 1'b1, "R2 date match");
        fire(7'h30, 7'h14, 7'h08, 7'h12, 1'b0, "R2 minute differs");

        // R4 no tick, no flag
        tm_sec = 7'h30; tm_min = 7'h15; tm_hour = 7'h08; tm_date = 7'h12;
        repeat (3) @(negedge clk);
        expect_pin(1'b1, "R4 no tick");
        tick();
        expect_pin(1'b0, "R4 tick sets");
        rd_chk(A_FLAG, 8'h01, "R4 flag read");
        expect_pin(1'b1, "R6 read clears pin");
        rd_chk(A_FLAG, 8'h00, "R6 read clears flag");

        // R2 daily, hourly, per-minute, every second
        wr(A_DATE, 8'h92);
        fire(7'h30, 7'h15, 7'h08, 7'h25, 1'b1, "R2 daily");
        fire(7'h30, 7'h15, 7'h09, 7'h25, 1'b0, "R2 daily hour differs");
        wr(A_HOUR, 8'h88);
        fire(7'h30, 7'h15, 7'h19, 7'h25, 1'b1, "R2 hourly");
        fire(7'h31, 7'h15, 7'h19, 7'h25, 1'b0, "R2 hourly sec differs");
        wr(A_MIN, 8'h95);
        fire(7'h30, 7'h44, 7'h19, 7'h25, 1'b1, "R2 per minute");
        fire(7'h29, 7'h44, 7'h19, 7'h25, 1'b0, "R2 per minute sec differs");
        wr(A_SEC, 8'hB0);
        fire(7'h01, 7'h02, 7'h03, 7'h04, 1'b1, "R2 every second");

        // R3 undefined masks
        set_alarm(8'hB0, 8'h15, 8'h88, 8'h12);
        fire(7'h07, 7'h22, 7'h03, 7'h01, 1'b1, "R3 mask 0101");
        set_alarm(8'hB0, 8'h15, 8'h08, 8'h12);
        fire(7'h07, 7'h22, 7'h03, 7'h01, 1'b1, "R3 mask 0001");
        set_alarm(8'h30, 8'h95, 8'h08, 8'h12);
        fire(7'h07, 7'h22, 7'h03, 7'h01, 1'b1, "R3 mask 0010");

        // R5 enable gating on main power
        set_alarm(8'hB0, 8'h95, 8'h88, 8'h92);
        wr(A_CTRL, 8'h00);
        tick();
        expect_pin(1'b1, "R5 AE off");
        rd_chk(A_FLAG, 8'h01, "R5 flag without AE");
        wr(A_CTRL, 8'h01);

        // R6 flag held through a long access, released after
        tick();
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = A_FLAG;
        push_pin(1'b0, "R6 held during access");
        push_rd(8'h01, "R6 flag during access");
        @(negedge clk);
        @(negedge clk);
        push_pin(1'b0, "R6 still held");
        @(negedge clk);
        bus_cs = 1'b0;
        @(negedge clk);
        expect_pin(1'b1, "R6 released");
        tick();
        wr(A_FLAG, 8'hFF);
        expect_pin(1'b1, "R6 write clears");
        rd_chk(A_FLAG, 8'h00, "R6 write data ignored");

        // R10 match on the clearing edge wins
        tick();
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = A_FLAG;
        @(negedge clk);
        bus_cs = 1'b0; sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        expect_pin(1'b0, "R10 match wins");
        wr(A_FLAG, 8'h00);
        expect_pin(1'b1, "R10 later clear");

        // R7 battery gating
        tick();
        on_batt = 1'b1;
        expect_pin(1'b1, "R7 battery AE only");
        wr(A_CTRL, 8'h03);
        expect_pin(1'b0, "R7 battery AE and ABE");
        wr(A_CTRL, 8'h02);
        expect_pin(1'b1, "R7 battery ABE only");
        on_batt = 1'b0;
        wr(A_CTRL, 8'h01);
        expect_pin(1'b0, "R5 main power AE");
        wr(A_FLAG, 8'h00);

        // R8 power-up
        wr(A_CTRL, 8'h07);
        tick();
        expect_pin(1'b0, "R8 before power-up");
        @(negedge clk); pwr_up = 1'b1;
        @(negedge clk); pwr_up = 1'b0;
        expect_pin(1'b1, "R8 enables cleared");
        rd_chk(A_CTRL, 8'h00, "R8 ctrl cleared");
        rd_chk(A_SEC, 8'hB0, "R8 alarm kept");
        rd_chk(A_FLAG, 8'h01, "R8 flag kept");

        // R9 frequency test
        wr(A_CTRL, 8'h04);
        half();
        expect_pin(1'b1, "R9 watchdog condition off");
        wd_zero = 1'b1;
        expect_pin(1'b1, "R9 starts high");
        half();
        expect_pin(1'b0, "R9 toggle low");
        half();
        expect_pin(1'b1, "R9 toggle high");
        wd_zero = 1'b0; wd_to_rst = 1'b1;
        half();
        expect_pin(1'b0, "R9 steered watchdog");
        wr(A_CTRL, 8'h05);
        expect_pin(1'b1, "R9 AE blocks wave");
        half();
        expect_pin(1'b1, "R9 half tick ignored");
        wr(A_CTRL, 8'h04);
        half();
        expect_pin(1'b0, "R9 wave again");
        @(negedge clk); pwr_up = 1'b1;
        @(negedge clk); pwr_up = 1'b0;
        expect_pin(1'b1, "R8 FT cleared");
        half();
        expect_pin(1'b1, "R8 wave stays off");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule